// File: doc/BRIEF.md
# Dual-Rate FIFO Board Demonstrator

This block wraps a 32-entry, 24-bit dual-clock FIFO so it can be exercised by hand on a development board. From the board oscillator it derives two slow clocks with separate dividers: a write clock at half the rate of the read clock (0.5 Hz and 1 Hz from 50 MHz). The write clock paces a 24-bit maximal-length LFSR, which supplies the data words. The read clock drives the pop side. Three active-low push buttons give push, pop and reset. Three LEDs show the FIFO state.

Six seven-segment digits show one of two values. A switch picks either the word at the FIFO head or the current fill count. Both the divider half-periods and the LFSR seed are parameters. The half-periods must be at least 2, and small values let a simulation run in a few thousand cycles.

Top module: `dfd_board_top`

## Requirements
- R1: While `key_n[2]` is low, and after it is released, the FIFO is empty: `led_status` reads 3'b100 and the fill count reads 0. Asserting it mid-run discards all stored entries within two board cycles.
- R2: The write clock has a period of 2*WR_HALF board cycles. With push held, pop released and the FIFO not full, the fill count rises by one every 2*WR_HALF board cycles.
- R3: The read clock has a period of 2*RD_HALF board cycles. With pop held and the FIFO not empty, the head word advances once every 2*RD_HALF board cycles.
- R4: The FIFO holds at most 32 entries. Holding push while full stores nothing more: the full LED stays on and the fill count stays at 32.
- R5: A pop with the FIFO empty does nothing. Draining a full FIFO takes exactly 32 pops. Further pops leave the fill at 0, and a later push gives a small positive fill and not a wrapped value.
- R6: The write data is a 24-bit Fibonacci LFSR with feedback s[23]^s[22]^s[21]^s[16] shifted into bit 0. It steps on every write-clock edge and is never zero. Entries pushed on consecutive write edges are therefore consecutive LFSR states, and they are read back in order.
- R7: `led_status` bit 0 is full, bit 1 is not-empty and bit 2 is empty.
- R8: Digit d (`hex_n[7d+6:7d]`) shows nibble d of the selected 24-bit word. Digit 0 is the least significant nibble. The segments are active low in the order {g,f,e,d,c,b,a}, using the usual hexadecimal glyphs (for example 0 = 7'h40, 1 = 7'h79, A = 7'h08). With `sw_sel` = 0 the word is the FIFO head entry. With `sw_sel` = 1 it is the fill count with zeros above it.
- R9: While `key_n[1:0]` are both high, the fill count and the LEDs do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_board | input | 1 | Board oscillator clock |
| key_n | input | 3 | Active-low buttons: bit 0 push, bit 1 pop, bit 2 reset |
| sw_sel | input | 1 | Display select: 0 head word, 1 fill count |
| led_status | output | 3 | Bit 0 full, bit 1 not-empty, bit 2 empty |
| hex_n | output | 42 | Six active-low seven-segment digits, digit 0 in bits 6:0 |

## Verification
The bench measures the spacing between fill-count steps and between head-word changes. A divider with the wrong terminal count, or write and read clocks swapped, shows up as the wrong interval. It keeps pushing long after the full LED lights, and it keeps popping after the empty LED lights. A pointer comparison that lets either side wrap would show a fill other than 32, a drain that is not exactly 32 pops, or a huge fill after the next push. While draining, every head word must be the LFSR successor of the one before it. A wrong tap, a wrong storage address, or an LFSR stepped only on pushes breaks that chain. Segment patterns are decoded against the glyph table, so a mis-wired segment or a display that shows the wrong digit order or the wrong source gives a digit that cannot be decoded or a wrong value.

// File: rtl/dfd_pkg.sv
package dfd_pkg;

  localparam int unsigned SEG_W = 7;
  localparam int unsigned NIB_W = 4;

  typedef enum logic {
    SHOW_HEAD = 1'b0,
    SHOW_FILL = 1'b1
  } disp_sel_e;

  // Active-low segments, bit order {g,f,e,d,c,b,a}
  function automatic logic [SEG_W-1:0] nib_to_seg_n(input logic [NIB_W-1:0] nib);
    logic [SEG_W-1:0] lit;
    case (nib)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
    return ~lit;
  endfunction

endpackage

// File: rtl/dfd_sync.sv
module dfd_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
    if (gs == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gs] <= '0;
        else        stage_q[gs] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gs] <= '0;
        else        stage_q[gs] <= stage_q[gs-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dfd_clk_div.sv
module dfd_clk_div #(
  parameter int unsigned HALF = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic clk_out
);

  localparam int unsigned    CW   = $clog2(HALF);
  localparam logic [CW-1:0]  LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tog_q, tog_d;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    tog_d = tog_q;
    if (cnt_q == LAST) begin
      cnt_d = '0;
      tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tog_q <= tog_d;
    end
  end

  assign clk_out = tog_q;

endmodule

// File: rtl/dfd_lfsr.sv
module dfd_lfsr #(
  parameter int unsigned  W    = 24,
  parameter logic [W-1:0] TAPS = 24'hE1_0000,
  parameter logic [W-1:0] SEED = 24'h5A_3C91
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);

  logic [W-1:0] st_q, st_d;
  logic         fb;

  always_comb begin
    fb   = ^(st_q & TAPS);
    st_d = {st_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/dfd_async_fifo.sv
module dfd_async_fifo #(
  parameter int unsigned DW          = 24,
  parameter int unsigned AW          = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push_req,
  input  logic [DW-1:0] wdata,
  output logic          full,
  output logic [AW:0]   wr_ptr,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop_req,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic [AW:0]   fill,
  output logic [AW:0]   rd_ptr
);

  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rgray_w;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wgray_r;
  logic          wr_fire, rd_fire;

  dfd_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w)
  );

  dfd_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r)
  );

  // write side
  always_comb begin
    full    = (wgray_q == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
    wr_fire = push_req & ~full;
    wbin_d  = wbin_q + PW'(1);
    wgray_d = to_gray(wbin_d);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_fire) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[wbin_q[AW-1:0]] <= wdata;
  end

  // read side
  always_comb begin
    empty   = (rgray_q == wgray_r);
    rd_fire = pop_req & ~empty;
    rbin_d  = rbin_q + PW'(1);
    rgray_d = to_gray(rbin_d);
    fill    = from_gray(wgray_r) - rbin_q;
    rdata   = mem[rbin_q[AW-1:0]];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (rd_fire) begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  assign wr_ptr = wbin_q;
  assign rd_ptr = rbin_q;

endmodule

// File: rtl/dfd_board_top.sv
module dfd_board_top
  import dfd_pkg::*;
#(
  parameter int unsigned WR_HALF = 50_000_000,
  parameter int unsigned RD_HALF = 25_000_000,
  parameter int unsigned DW      = 24,
  parameter int unsigned AW      = 5,
  parameter logic [23:0] SEED    = 24'h5A_3C91,
  parameter logic [23:0] TAPS    = 24'hE1_0000,
  parameter int unsigned DIGITS  = DW / NIB_W
) (
  input  logic                      clk_board,
  input  logic [2:0]                key_n,
  input  logic                      sw_sel,
  output logic [2:0]                led_status,
  output logic [SEG_W*DIGITS-1:0]   hex_n
);

  localparam int unsigned PW = AW + 1;

  logic          rst_b_n, rst_w_n, rst_r_n;
  logic          clk_wr, clk_rd;
  logic          push_w, pop_r;
  logic [DW-1:0] lfsr_q, head_q, disp_word;
  logic          full, empty;
  logic [PW-1:0] fill, wptr, rptr;
  disp_sel_e     sel;

  // reset: asserted at once, released through two flops per domain
  dfd_sync #(.W(1), .STAGES(2)) u_rst_b (
    .clk(clk_board), .rst_n(key_n[2]), .d(1'b1), .q(rst_b_n)
  );

  dfd_clk_div #(.HALF(WR_HALF)) u_div_wr (
    .clk(clk_board), .rst_n(rst_b_n), .clk_out(clk_wr)
  );

  dfd_clk_div #(.HALF(RD_HALF)) u_div_rd (
    .clk(clk_board), .rst_n(rst_b_n), .clk_out(clk_rd)
  );

  dfd_sync #(.W(1), .STAGES(2)) u_rst_w (
    .clk(clk_wr), .rst_n(rst_b_n), .d(1'b1), .q(rst_w_n)
  );

  dfd_sync #(.W(1), .STAGES(2)) u_rst_r (
    .clk(clk_rd), .rst_n(rst_b_n), .d(1'b1), .q(rst_r_n)
  );

  // buttons are active low: invert, then bring into the using domain
  dfd_sync #(.W(1), .STAGES(2)) u_push_sync (
    .clk(clk_wr), .rst_n(rst_w_n), .d(~key_n[0]), .q(push_w)
  );

  dfd_sync #(.W(1), .STAGES(2)) u_pop_sync (
    .clk(clk_rd), .rst_n(rst_r_n), .d(~key_n[1]), .q(pop_r)
  );

  dfd_lfsr #(.W(DW), .TAPS(TAPS[DW-1:0]), .SEED(SEED[DW-1:0])) u_lfsr (
    .clk(clk_wr), .rst_n(rst_w_n), .state(lfsr_q)
  );

  dfd_async_fifo #(.DW(DW), .AW(AW), .SYNC_STAGES(2)) u_fifo (
    .wclk(clk_wr), .wrst_n(rst_w_n), .push_req(push_w), .wdata(lfsr_q),
    .full(full), .wr_ptr(wptr),
    .rclk(clk_rd), .rrst_n(rst_r_n), .pop_req(pop_r), .rdata(head_q),
    .empty(empty), .fill(fill), .rd_ptr(rptr)
  );

  always_comb begin
    led_status = {empty, ~empty, full};
    sel        = disp_sel_e'(sw_sel);
    case (sel)
      SHOW_FILL: disp_word = {{(DW-PW){1'b0}}, fill};
      default:   disp_word = head_q;
    endcase
  end

  for (genvar gd = 0; gd < DIGITS; gd++) begin : g_digit
    assign hex_n[SEG_W*gd +: SEG_W] = nib_to_seg_n(disp_word[NIB_W*gd +: NIB_W]);
  end

endmodule

// File: rtl/dfd_board_chk.sv
module dfd_board_chk #(
  parameter int unsigned DW = 24,
  parameter int unsigned AW = 5
) (
  input logic          wclk,
  input logic          rclk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          full,
  input logic          empty,
  input logic [AW:0]   wptr,
  input logic [AW:0]   rptr,
  input logic [AW:0]   fill,
  input logic [DW-1:0] lfsr
);

  localparam logic [AW:0] CAP = {1'b1, {AW{1'b0}}};

  // R4: no write while full
  p_wptr_frozen_full_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |=> $stable(wptr));

  // R5: no read while empty
  p_rptr_frozen_empty_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |=> $stable(rptr));

  // R2: write pointer moves by at most one per write edge
  p_wptr_step_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wptr == $past(wptr)) || (wptr == (AW+1)'($past(wptr) + 1'b1)));

  // R3: read pointer moves by at most one per read edge
  p_rptr_step_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rptr == $past(rptr)) || (rptr == (AW+1)'($past(rptr) + 1'b1)));

  // R4: fill never exceeds capacity
  p_fill_bound_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    fill <= CAP);

  // R6: data source never locks up at zero
  p_lfsr_nonzero_r6: assert property (@(posedge wclk) disable iff (!wrst_n)
    lfsr != '0);

endmodule

bind dfd_board_top dfd_board_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(clk_wr), .rclk(clk_rd), .wrst_n(rst_w_n), .rrst_n(rst_r_n),
  .full(full), .empty(empty), .wptr(wptr), .rptr(rptr),
  .fill(fill), .lfsr(lfsr_q)
);

// File: tb/tb_dfd_board_top.sv
module tb_dfd_board_top;

  localparam int WR_HALF = 6;
  localparam int RD_HALF = 3;
  localparam int WR_PER  = 2 * WR_HALF;
  localparam int RD_PER  = 2 * RD_HALF;
  localparam int DW      = 24;
  localparam int DIG     = DW / 4;
  localparam int DEPTH   = 32;

  // active-high glyphs {g..a}; the port carries the inverse
  localparam logic [6:0] GLYPH [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D,
    7'h7D, 7'h07, 7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};

  // {press[1:0] (bit1 pop, bit0 push), sw, wait[9:0], led[2:0], fill_dc, fill[5:0]}
  localparam int NSTEP = 5;
  localparam logic [22:0] STEPS [NSTEP] = '{
    {2'b00, 1'b1, 10'd60,  3'b100, 1'b0, 6'd0},
    {2'b01, 1'b1, 10'd200, 3'b010, 1'b1, 6'd0},
    {2'b00, 1'b1, 10'd150, 3'b010, 1'b1, 6'd0},
    {2'b10, 1'b1, 10'd900, 3'b100, 1'b0, 6'd0},
    {2'b00, 1'b1, 10'd60,  3'b100, 1'b0, 6'd0}
  };

  logic              clk = 1'b0;
  logic [2:0]        key_n;
  logic              sw_sel;
  logic [2:0]        led_status;
  logic [7*DIG-1:0]  hex_n;

  int unsigned cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dfd_board_top #(.WR_HALF(WR_HALF), .RD_HALF(RD_HALF)) dut (
    .clk_board(clk), .key_n(key_n), .sw_sel(sw_sel),
    .led_status(led_status), .hex_n(hex_n)
  );

  function automatic logic [23:0] lfsr_next(input logic [23:0] s);
    return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_word(output logic [DW-1:0] w, output bit ok);
    ok = 1'b1;
    w  = '0;
    for (int d = 0; d < DIG; d++) begin
      bit found = 1'b0;
      for (int v = 0; v < 16; v++) begin
        if (hex_n[7*d +: 7] == ~GLYPH[v]) begin
          w[4*d +: 4] = 4'(v);
          found = 1'b1;
        end
      end
      if (!found) ok = 1'b0;
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w, prev, h0, f;
    bit            ok;
    int unsigned   tlast;
    int            changes, pops;

    key_n  = 3'b011;
    sw_sel = 1'b1;
    tick(5);
    key_n = 3'b111;
    tick(100);

    // R1: state after reset
    read_word(w, ok);
    check(led_status == 3'b100, "R1 led after reset", led_status, 3'b100);
    check(ok && w == 0, "R1 fill after reset", w, 0);

    // stimulus table
    for (int s = 0; s < NSTEP; s++) begin
      key_n[1:0] = ~STEPS[s][22:21];
      sw_sel     = STEPS[s][20];
      tick(int'(STEPS[s][19:10]));
      check(led_status == STEPS[s][9:7], "R7 table leds", led_status, STEPS[s][9:7]);
      if (!STEPS[s][6]) begin
        read_word(w, ok);
        check(ok && w == 24'(STEPS[s][5:0]), "R5 table fill", w, STEPS[s][5:0]);
      end
    end
    key_n[1:0] = 2'b11;
    tick(50);

    // R2: write pacing, then R4 saturation
    sw_sel = 1'b1;
    tick(2);
    read_word(prev, ok);
    key_n[0] = 1'b0;
    changes = 0;
    tlast = cyc;
    for (int i = 0; i < 2000 && changes < 7; i++) begin
      tick(1);
      read_word(w, ok);
      if (w != prev) begin
        changes++;
        if (changes > 1) check(cyc - tlast == WR_PER, "R2 fill step interval", cyc - tlast, WR_PER);
        tlast = cyc;
        prev = w;
      end
    end
    for (int i = 0; i < 2000 && !led_status[0]; i++) tick(1);
    tick(20 * WR_PER);
    key_n[0] = 1'b1;
    tick(100);
    read_word(w, ok);
    check(w == DEPTH, "R4 fill at capacity", w, DEPTH);
    check(led_status == 3'b011, "R7 leds when full", led_status, 3'b011);
    check(w[DW-1:8] == 0, "R8 fill zero-extended", w, DEPTH);
    check(ok, "R8 fill glyphs decode", hex_n[31:0], 0);

    // R3 / R6 / R5: drain and follow the LFSR chain
    sw_sel = 1'b0;
    tick(2);
    read_word(h0, ok);
    check(ok, "R8 head glyphs decode", hex_n[31:0], 0);
    check(h0 != 0, "R6 head nonzero", h0, 1);
    key_n[1] = 1'b0;
    prev = h0;
    pops = 0;
    tlast = cyc;
    for (int i = 0; i < 4000 && !led_status[2]; i++) begin
      tick(1);
      read_word(w, ok);
      if (w != prev) begin
        pops++;
        if (pops > 1) check(cyc - tlast == RD_PER, "R3 pop interval", cyc - tlast, RD_PER);
        if (led_status[2]) check(w == h0, "R6 pointer wrap to first entry", w, h0);
        else               check(w == lfsr_next(prev), "R6 next entry is LFSR successor", w, lfsr_next(prev));
        tlast = cyc;
        prev = w;
      end
    end
    check(pops == DEPTH, "R5 pops to drain", pops, DEPTH);

    // R5: popping while empty
    tick(30 * RD_PER);
    sw_sel = 1'b1;
    tick(2);
    read_word(w, ok);
    check(w == 0, "R5 fill stays zero", w, 0);
    check(led_status == 3'b100, "R5 leds stay empty", led_status, 3'b100);
    key_n[1] = 1'b1;
    tick(20);
    key_n[0] = 1'b0;
    for (int i = 0; i < 500; i++) begin
      tick(1);
      read_word(w, ok);
      if (w != 0) break;
    end
    key_n[0] = 1'b1;
    tick(150);
    read_word(w, ok);
    check(w >= 1 && w <= 6, "R5 small fill after underflow attempt", w, 1);

    // R9: idle buttons
    f = w;
    tick(300);
    read_word(w, ok);
    check(w == f, "R9 fill stable when idle", w, f);
    check(led_status == 3'b010, "R9 leds stable when idle", led_status, 3'b010);

    // R1: reset in mid-run
    key_n[2] = 1'b0;
    tick(2);
    read_word(w, ok);
    check(led_status == 3'b100, "R1 led during reset", led_status, 3'b100);
    check(w == 0, "R1 fill during reset", w, 0);
    key_n[2] = 1'b1;
    tick(100);
    read_word(w, ok);
    check(led_status == 3'b100, "R1 led after release", led_status, 3'b100);
    check(w == 0, "R1 fill after release", w, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule